// File: doc/BRIEF.md
# Private Memory Address Translator

This block maps an address in a thread's private memory space onto one or more word addresses in a memory space shared by every thread of the chip. Threads that run at the same time are interleaved word by word: word k of every live thread sits in one contiguous stripe, so a warp touching the same private word produces adjacent addresses. A wide access becomes several 4-byte word requests. A sub-word access becomes one request that keeps its byte offset inside the word.

Two mapping modes exist, selected by a latched configuration bit. In group mode, threads are first grouped by thread group (padded group size T), then spread across cores. This needs a quotient and a remainder of the thread id by T, which a small serial divider produces. In flat mode, each core owns a block of threads-per-core slots.

Configuration is latched when the kernel starts. Requests arrive through a valid/ready handshake. Each result is presented with a lane count and an error flag until it is taken.

Top module: `lmx_translator`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: From the cycle a request is accepted until its result is taken, in_ready is 0. While out_valid is 1 and out_ready is 0, out_addr, out_count and out_err hold steady.
- R3: In flat mode (cfg_cta_mode=0), the word base is P·S+tid and the concurrent thread count M is N·P. Here P is cfg_threads_per_core, S is cfg_core_id and N is cfg_num_cores.
- R4: In group mode (cfg_cta_mode=1), the word base is T·(S+N·(tid/T))+(tid mod T) and M is T·C·N. Here T is cfg_pad_threads and C is cfg_ctas_per_core.
- R5: For a size of 4 bytes or more, out_count is size/4. Lane i (bits [32i+31:32i] of out_addr) is ((addr/4)+i)·4M + 4·base + cfg_region_base. Lanes at or above out_count are 0.
- R6: For a size of 1 to 3 bytes, out_count is 1 and lane 0 is (addr/4)·4M + (addr mod 4) + 4·base + cfg_region_base.
- R7: A size of 4 or more that is not a multiple of 4, or that comes with an address not 4-byte aligned, sets out_err. Whenever out_err is 1, out_count is 0 and every lane is 0.
- R8: A size above 32 bytes, which would need more than 8 lanes, sets out_err.
- R9: A sub-word access whose bytes cross a 4-byte boundary sets out_err.
- R10: A word base not below M sets out_err.
- R11: A size of 0 sets out_err. Group mode with T=0 sets out_err.
- R12: Configuration inputs are latched only by cfg_load while in_ready is 1. Otherwise cfg_load and changes on the cfg inputs do not affect results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Latch the configuration inputs |
| cfg_cta_mode | input | 1 | 1 = group mode, 0 = flat mode |
| cfg_core_id | input | CORE_W | Core index S |
| cfg_num_cores | input | CORE_W | Core count N |
| cfg_pad_threads | input | TID_W | Padded threads per group T |
| cfg_ctas_per_core | input | CTA_W | Groups per core C |
| cfg_threads_per_core | input | TID_W | Thread slots per core P |
| cfg_region_base | input | AW | Start of the shared private region |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block can accept a request |
| in_local_addr | input | AW | Private byte address |
| in_tid | input | TID_W | Hardware thread id |
| in_size | input | SZ_W | Access size in bytes |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken |
| out_addr | output | MAX_ACC·AW | Translated word addresses, lane 0 in the low bits |
| out_count | output | CNT_W | Number of valid lanes |
| out_err | output | 1 | Request violated a rule |

## Verification
Two things can land in the same cycle. One is a configuration load. The other is a result stalled at the output waiting for out_ready. The bench holds out_ready low on a finished result, pulses cfg_load with different values during the stall, and then leaves the cfg inputs changed without a load. It judges the outcome two ways. The stalled result must not move. The next request must be translated with the earlier configuration, and the bench compares every lane against its own computation.

// File: rtl/lmx_pkg.sv
package lmx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_OUT  = 2'd2
  } lmx_state_e;

  localparam int WORD_LG2 = 2;
endpackage

// File: rtl/lmx_div.sv
module lmx_div #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  acc_q, acc_d, qr_q, qr_d, dv_q, dv_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic [W:0]    trial;
  logic          en;

  assign trial = {acc_q, qr_q[W-1]};
  assign en    = start || busy_q;
  assign done  = busy_q && (cnt_q == CW'(W-1));

  always_comb begin
    acc_d  = acc_q;
    qr_d   = qr_q;
    dv_d   = dv_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      acc_d  = '0;
      qr_d   = dividend;
      dv_d   = divisor;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (trial >= {1'b0, dv_q}) begin
        acc_d = W'(trial - {1'b0, dv_q});
        qr_d  = {qr_q[W-2:0], 1'b1};
      end else begin
        acc_d = trial[W-1:0];
        qr_d  = {qr_q[W-2:0], 1'b0};
      end
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(W-1)) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      qr_q   <= '0;
      dv_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (en) begin
      acc_q  <= acc_d;
      qr_q   <= qr_d;
      dv_q   <= dv_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign quot = qr_q;
  assign rem  = acc_q;
endmodule

// File: rtl/lmx_addr_gen.sv
module lmx_addr_gen #(
  parameter int AW      = 32,
  parameter int TID_W   = 12,
  parameter int CORE_W  = 6,
  parameter int CTA_W   = 6,
  parameter int SZ_W    = 6,
  parameter int MAX_ACC = 8,
  parameter int CNT_W   = 4
) (
  input  logic                  cta_mode,
  input  logic [CORE_W-1:0]     core_id,
  input  logic [CORE_W-1:0]     num_cores,
  input  logic [TID_W-1:0]      pad_threads,
  input  logic [CTA_W-1:0]      ctas_per_core,
  input  logic [TID_W-1:0]      threads_per_core,
  input  logic [AW-1:0]         region_base,
  input  logic [AW-1:0]         local_addr,
  input  logic [TID_W-1:0]      tid,
  input  logic [SZ_W-1:0]       size,
  input  logic [TID_W-1:0]      quot,
  input  logic [TID_W-1:0]      rem,
  output logic [MAX_ACC*AW-1:0] addr_flat,
  output logic [CNT_W-1:0]      count,
  output logic                  err
);
  import lmx_pkg::*;

  logic [AW-1:0]      s_x, n_x, t_x, c_x, p_x;
  logic [AW-1:0]      word_base, max_thr, thread_base, stride, word_idx;
  logic [SZ_W-3:0]    n_words;
  logic               wide, e_zero, e_align, e_cap, e_cross, e_range, e_div;
  logic [1:0]         byte_off;

  assign s_x = AW'(core_id);
  assign n_x = AW'(num_cores);
  assign t_x = AW'(pad_threads);
  assign c_x = AW'(ctas_per_core);
  assign p_x = AW'(threads_per_core);

  always_comb begin
    if (cta_mode) begin
      word_base = t_x * (s_x + n_x * AW'(quot)) + AW'(rem);
      max_thr   = t_x * c_x * n_x;
    end else begin
      word_base = p_x * s_x + AW'(tid);
      max_thr   = n_x * p_x;
    end
  end

  assign thread_base = word_base << WORD_LG2;
  assign stride      = max_thr << WORD_LG2;
  assign word_idx    = local_addr >> WORD_LG2;
  assign n_words     = size[SZ_W-1:2];
  assign byte_off    = local_addr[1:0];
  assign wide        = (size >= SZ_W'(4));

  assign e_zero  = (size == '0);
  assign e_align = wide && ((size[1:0] != 2'b00) || (byte_off != 2'b00));
  assign e_cap   = wide && (int'(n_words) > MAX_ACC);
  assign e_cross = !wide && (int'(byte_off) + int'(size) > 4);
  assign e_range = (word_base >= max_thr);
  assign e_div   = cta_mode && (pad_threads == '0);
  assign err     = e_zero || e_align || e_cap || e_cross || e_range || e_div;

  always_comb begin
    if (err)       count = '0;
    else if (wide) count = CNT_W'(n_words);
    else           count = CNT_W'(1);
  end

  for (genvar i = 0; i < MAX_ACC; i++) begin : g_lane
    logic [AW-1:0] lane_addr;
    assign lane_addr = (word_idx + AW'(i)) * stride + thread_base + region_base
                       + (wide ? '0 : AW'(byte_off));
    assign addr_flat[i*AW +: AW] = (i < int'(count)) ? lane_addr : '0;
  end
endmodule

// File: rtl/lmx_translator.sv
module lmx_translator #(
  parameter int AW      = 32,
  parameter int TID_W   = 12,
  parameter int CORE_W  = 6,
  parameter int CTA_W   = 6,
  parameter int SZ_W    = 6,
  parameter int MAX_ACC = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_load,
  input  logic                          cfg_cta_mode,
  input  logic [CORE_W-1:0]             cfg_core_id,
  input  logic [CORE_W-1:0]             cfg_num_cores,
  input  logic [TID_W-1:0]              cfg_pad_threads,
  input  logic [CTA_W-1:0]              cfg_ctas_per_core,
  input  logic [TID_W-1:0]              cfg_threads_per_core,
  input  logic [AW-1:0]                 cfg_region_base,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [AW-1:0]                 in_local_addr,
  input  logic [TID_W-1:0]              in_tid,
  input  logic [SZ_W-1:0]               in_size,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [MAX_ACC*AW-1:0]         out_addr,
  output logic [$clog2(MAX_ACC+1)-1:0]  out_count,
  output logic                          out_err
);
  import lmx_pkg::*;

  localparam int CNT_W = $clog2(MAX_ACC + 1);

  lmx_state_e state_q, state_d;

  logic                cta_q;
  logic [CORE_W-1:0]   core_q, ncores_q;
  logic [TID_W-1:0]    pad_q, tpc_q;
  logic [CTA_W-1:0]    ctas_q;
  logic [AW-1:0]       region_q;
  logic [AW-1:0]       req_addr_q;
  logic [TID_W-1:0]    req_tid_q;
  logic [SZ_W-1:0]     req_size_q;

  logic                cfg_en, accept, eff_mode, div_start, div_done;
  logic [TID_W-1:0]    eff_pad, quot, rem;

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_OUT);
  assign cfg_en    = cfg_load && in_ready;
  assign accept    = in_valid && in_ready;
  assign eff_mode  = cfg_en ? cfg_cta_mode : cta_q;
  assign eff_pad   = cfg_en ? cfg_pad_threads : pad_q;
  assign div_start = accept && eff_mode;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept)    state_d = eff_mode ? ST_DIV : ST_OUT;
      ST_DIV:  if (div_done)  state_d = ST_OUT;
      ST_OUT:  if (out_ready) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cta_q    <= 1'b0;
      core_q   <= '0;
      ncores_q <= '0;
      pad_q    <= '0;
      tpc_q    <= '0;
      ctas_q   <= '0;
      region_q <= '0;
    end else if (cfg_en) begin
      cta_q    <= cfg_cta_mode;
      core_q   <= cfg_core_id;
      ncores_q <= cfg_num_cores;
      pad_q    <= cfg_pad_threads;
      tpc_q    <= cfg_threads_per_core;
      ctas_q   <= cfg_ctas_per_core;
      region_q <= cfg_region_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_addr_q <= '0;
      req_tid_q  <= '0;
      req_size_q <= '0;
    end else if (accept) begin
      req_addr_q <= in_local_addr;
      req_tid_q  <= in_tid;
      req_size_q <= in_size;
    end
  end

  lmx_div #(.W(TID_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (in_tid),
    .divisor  (eff_pad),
    .done     (div_done),
    .quot     (quot),
    .rem      (rem)
  );

  lmx_addr_gen #(
    .AW(AW), .TID_W(TID_W), .CORE_W(CORE_W), .CTA_W(CTA_W),
    .SZ_W(SZ_W), .MAX_ACC(MAX_ACC), .CNT_W(CNT_W)
  ) u_gen (
    .cta_mode         (cta_q),
    .core_id          (core_q),
    .num_cores        (ncores_q),
    .pad_threads      (pad_q),
    .ctas_per_core    (ctas_q),
    .threads_per_core (tpc_q),
    .region_base      (region_q),
    .local_addr       (req_addr_q),
    .tid              (req_tid_q),
    .size             (req_size_q),
    .quot             (quot),
    .rem              (rem),
    .addr_flat        (out_addr),
    .count            (out_count),
    .err              (out_err)
  );
endmodule

// File: rtl/lmx_translator_chk.sv
module lmx_translator_chk #(
  parameter int AW      = 32,
  parameter int SZ_W    = 6,
  parameter int MAX_ACC = 8,
  parameter int CNT_W   = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [MAX_ACC*AW-1:0] out_addr,
  input logic [CNT_W-1:0]      out_count,
  input logic                  out_err,
  input logic [SZ_W-1:0]       req_size
);
  a_r2_busy_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r2_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
                                   && $stable(out_count) && $stable(out_err)));

  a_r7_error_clears_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_count == '0 && out_addr == '0));

  a_r8_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_count) <= MAX_ACC));

  a_r6_subword_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err && req_size < SZ_W'(4)) |-> (out_count == CNT_W'(1)));
endmodule

bind lmx_translator lmx_translator_chk #(
  .AW(AW), .SZ_W(SZ_W), .MAX_ACC(MAX_ACC), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .out_count (out_count),
  .out_err   (out_err),
  .req_size  (req_size_q)
);

// File: tb/lmx_translator_test.sv
module lmx_translator_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, TID_W = 12, CORE_W = 6, CTA_W = 6, SZ_W = 6, MAX_ACC = 8;
  localparam int CNT_W = $clog2(MAX_ACC + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_load, cfg_cta_mode;
  logic [CORE_W-1:0] cfg_core_id, cfg_num_cores;
  logic [TID_W-1:0] cfg_pad_threads, cfg_threads_per_core;
  logic [CTA_W-1:0] cfg_ctas_per_core;
  logic [AW-1:0] cfg_region_base;
  logic in_valid, in_ready, out_valid, out_ready, out_err;
  logic [AW-1:0] in_local_addr;
  logic [TID_W-1:0] in_tid;
  logic [SZ_W-1:0] in_size;
  logic [MAX_ACC*AW-1:0] out_addr;
  logic [CNT_W-1:0] out_count;

  int checks = 0, errors = 0, cycles = 0;
  bit m_cta;
  int unsigned m_s, m_n, m_t, m_c, m_p;
  logic [31:0] m_region;

  always #(CLK_PERIOD/2) clk = ~clk;

  lmx_translator uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_cta_mode(cfg_cta_mode),
    .cfg_core_id(cfg_core_id), .cfg_num_cores(cfg_num_cores),
    .cfg_pad_threads(cfg_pad_threads), .cfg_ctas_per_core(cfg_ctas_per_core),
    .cfg_threads_per_core(cfg_threads_per_core), .cfg_region_base(cfg_region_base),
    .in_valid(in_valid), .in_ready(in_ready), .in_local_addr(in_local_addr),
    .in_tid(in_tid), .in_size(in_size), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_count(out_count), .out_err(out_err)
  );

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected < 50000", cycles);
      finish_run();
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic load_cfg(bit cta, int unsigned s, int unsigned n, int unsigned t,
                          int unsigned c, int unsigned p, logic [31:0] region);
    @(negedge clk);
    cfg_cta_mode = cta; cfg_core_id = CORE_W'(s); cfg_num_cores = CORE_W'(n);
    cfg_pad_threads = TID_W'(t); cfg_ctas_per_core = CTA_W'(c);
    cfg_threads_per_core = TID_W'(p); cfg_region_base = region;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    m_cta = cta; m_s = s; m_n = n; m_t = t; m_c = c; m_p = p; m_region = region;
  endtask

  function automatic void model(input logic [31:0] la, input int unsigned tid,
                                input int unsigned size, output logic [31:0] ea [MAX_ACC],
                                output int unsigned ecnt, output bit eerr);
    logic [31:0] wb, mx;
    int unsigned q, r;
    q = 0; r = 0;
    if (m_cta && m_t != 0) begin q = tid / m_t; r = tid % m_t; end
    if (m_cta) begin wb = m_t * (m_s + m_n * q) + r; mx = m_t * m_c * m_n; end
    else begin wb = m_p * m_s + tid; mx = m_n * m_p; end
    eerr = (size == 0) || (m_cta && m_t == 0) || (wb >= mx)
        || (size >= 4 && ((size % 4) != 0 || (la % 4) != 0 || size / 4 > MAX_ACC))
        || (size < 4 && (la % 4) + size > 4);
    ecnt = eerr ? 0 : (size >= 4 ? size / 4 : 1);
    for (int i = 0; i < MAX_ACC; i++)
      ea[i] = (i < int'(ecnt)) ? ((la >> 2) + i) * (mx * 4) + wb * 4 + m_region
                                 + (size < 4 ? la % 4 : 0) : 32'h0;
  endfunction

  task automatic do_req(string req, logic [31:0] la, int unsigned tid, int unsigned size,
                        bit poke_cfg);
    logic [31:0] ea [MAX_ACC];
    int unsigned ecnt;
    bit eerr;
    logic [31:0] held;
    int wait_n;
    model(la, tid, size, ea, ecnt, eerr);
    @(negedge clk);
    in_valid = 1'b1; in_local_addr = la; in_tid = TID_W'(tid); in_size = SZ_W'(size);
    wait_n = 0;
    while (!in_ready && wait_n < 100) begin @(negedge clk); wait_n++; end
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", "in_ready after accept", 32'(in_ready), 32'h0);
    wait_n = 0;
    while (!out_valid && wait_n < 100) begin
      @(negedge clk);
      wait_n++;
      if (!out_valid) check("R2", "in_ready while busy", 32'(in_ready), 32'h0);
    end
    check(req, "out_valid", 32'(out_valid), 32'h1);
    check(req, "out_err", 32'(out_err), 32'(eerr));
    check(req, "out_count", 32'(out_count), ecnt);
    for (int i = 0; i < MAX_ACC; i++)
      check(req, $sformatf("lane %0d", i), out_addr[i*AW +: AW], ea[i]);
    held = out_addr[AW-1:0];
    if (poke_cfg) begin
      cfg_cta_mode = ~m_cta; cfg_core_id = 6'd9; cfg_num_cores = 6'd13;
      cfg_pad_threads = 12'd7; cfg_ctas_per_core = 6'd5; cfg_threads_per_core = 12'd99;
      cfg_region_base = 32'hDEAD_0000;
      cfg_load = 1'b1;
    end
    @(negedge clk);
    cfg_load = 1'b0;
    @(negedge clk);
    check("R2", "out_valid held", 32'(out_valid), 32'h1);
    check("R2", "lane 0 held", out_addr[AW-1:0], held);
    check("R2", "count held", 32'(out_count), ecnt);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R2", "in_ready after take", 32'(in_ready), 32'h1);
    check("R2", "out_valid after take", 32'(out_valid), 32'h0);
  endtask

  task automatic t_reset();
    check("R1", "out_valid in reset", 32'(out_valid), 32'h0);
    check("R1", "in_ready in reset", 32'(in_ready), 32'h1);
  endtask

  task automatic t_flat();
    load_cfg(1'b0, 3, 4, 0, 0, 64, 32'h1000_0000);
    do_req("R3", 32'h8, 10, 8, 1'b0);
    do_req("R5", 32'h40, 17, 32, 1'b0);
    do_req("R6", 32'h13, 5, 1, 1'b0);
  endtask

  task automatic t_group();
    load_cfg(1'b1, 1, 4, 32, 2, 0, 32'h2000_0000);
    do_req("R4", 32'h4, 45, 4, 1'b0);
    do_req("R4", 32'h11, 70, 2, 1'b0);
    do_req("R5", 32'h20, 127, 16, 1'b0);
  endtask

  task automatic t_errors();
    load_cfg(1'b0, 3, 4, 0, 0, 64, 32'h1000_0000);
    do_req("R7", 32'h8, 1, 6, 1'b0);
    do_req("R7", 32'h2, 1, 8, 1'b0);
    do_req("R8", 32'h0, 1, 36, 1'b0);
    do_req("R9", 32'h3, 1, 2, 1'b0);
    do_req("R10", 32'h0, 255, 4, 1'b0);
    do_req("R11", 32'h0, 1, 0, 1'b0);
    load_cfg(1'b1, 0, 2, 0, 2, 0, 32'h0);
    do_req("R11", 32'h0, 1, 4, 1'b0);
  endtask

  task automatic t_cfg();
    load_cfg(1'b1, 2, 4, 16, 3, 0, 32'h3000_0000);
    do_req("R12", 32'h4, 20, 8, 1'b1);
    do_req("R12", 32'h8, 33, 4, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_load = 1'b0; cfg_cta_mode = 1'b0; cfg_core_id = '0;
    cfg_num_cores = '0; cfg_pad_threads = '0; cfg_ctas_per_core = '0;
    cfg_threads_per_core = '0; cfg_region_base = '0; in_valid = 1'b0;
    in_local_addr = '0; in_tid = '0; in_size = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_flat();
    t_group();
    t_errors();
    t_cfg();
    finish_run();
  end
endmodule